// File: doc/BRIEF.md
# Maskable Time-of-Day Alarm Unit

This block holds a three-byte alarm setting (minutes, hours, day of week) and compares it with the running time that a separate clock core supplies. The clock core pulses a minute-boundary strobe once per minute, in the 1/100-second tick where hundredths read 99 and seconds are rolling from 59 to 00. In that cycle it also presents the time registers' values. If the comparison succeeds, an alarm flag is set and an active-low interrupt request is driven.

The top bit of each alarm byte is a "don't care" mask for its own field. The masks select how often the alarm fires:
- With no masks set, the alarm fires once a week.
- With the day mask set, it fires once a day.
- With the day and hour masks set, it fires once an hour.
- With all three masks set, it fires at every minute boundary.

Software reaches the alarm bytes through a byte-wide register port at addresses 3 (minutes), 5 (hours) and 7 (day). Any read or write that hits one of these addresses also acknowledges the alarm.

Top module: `tod_alarm_unit`

## Requirements
- R1: After reset, all three alarm bytes read 0x00, the flag is 0 and the interrupt output is high.
- R2: A write with select and write-enable high to address 3, 5 or 7 stores the data byte, including bit 7 (the mask). The byte reads back combinationally at that address from the next cycle on. Any other address reads 0x00, and writes to other addresses change nothing.
- R3: In the day byte at address 7, bits 6 to 3 always read 0. Bit 7 (the mask) and bits 2 to 0 (the day) keep their written values.
- R4: With no mask bits set, a minute-boundary strobe sets the flag only when three fields all equal the running time. These are bits 6:0 of the minutes byte, bits 6:0 of the hours byte, and bits 2:0 of the day byte. The hours bits include bit 6 (the 12/24-hour select) and bit 5 (AM/PM or 20-hour), so both formats are compared as stored.
- R5: With only the day mask set (address 7 bit 7), the strobe sets the flag whenever minutes and hours match, whatever the day.
- R6: With the day and hour masks set (address 5 bit 7 as well), the strobe sets the flag whenever minutes match.
- R7: With all three masks set (address 3 bit 7 as well), every strobe sets the flag.
- R8: The flag rises in the cycle after a matching strobe. The interrupt output equals the inverse of the flag and stays low until the flag is cleared.
- R9: A read or write (select high) to address 3, 5 or 7 clears the flag on the next cycle. An access to any other address leaves the flag unchanged.
- R10: When a matching strobe and an alarm-byte access fall in the same cycle, the flag ends up set, so the new event is not lost.
- R11: The flag is set only in the cycle after a strobe. A time that keeps matching between strobes does not raise it again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| min_edge_i | input | 1 | Minute-boundary strobe from the clock core |
| cur_min_i | input | 7 | Running minutes, BCD |
| cur_hour_i | input | 7 | Running hours with format bits |
| cur_day_i | input | 3 | Running day of week |
| alarm_flag_o | output | 1 | Alarm flag |
| alarm_irq_no | output | 1 | Active-low interrupt request |

## Verification
The alarm is tried under each mask setting with patterns that differ from the alarm setting in exactly one field. A mismatched day tells the weekly mode from the daily one. A mismatched hour, including a difference only in the 12/24 select bit, tells daily from hourly. A mismatched minute tells hourly from per-minute. Strobe-free stretches with a matching time separate the event-driven flag from a level compare. Accesses to neighbouring addresses, and accesses in the same cycle as a strobe, check that only the three alarm addresses acknowledge and that a new event takes priority. A pseudo-random phase then mixes mask writes, strobes and accesses against the bench's behavioural model.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  // Which alarm byte an access hits
  typedef enum logic [1:0] {
    SLOT_MIN  = 2'd0,
    SLOT_HOUR = 2'd1,
    SLOT_DAY  = 2'd2,
    SLOT_NONE = 2'd3
  } slot_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MASK_POS = 7;   // don't-care bit in every alarm byte
  localparam int unsigned MIN_W    = 7;   // compared minute bits
  localparam int unsigned HOUR_W   = 7;   // compared hour bits incl. format bits
  localparam int unsigned DAY_W    = 3;   // compared day bits
  localparam int unsigned ADR_MIN  = 3;
  localparam int unsigned ADR_HOUR = 5;
  localparam int unsigned ADR_DAY  = 7;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic [BYTE_W-1:0]   min_q_o,
  output logic [BYTE_W-1:0]   hour_q_o,
  output logic [BYTE_W-1:0]   day_q_o,
  output logic                access_o
);
  localparam int unsigned PAD_W = BYTE_W - 1 - DAY_W;

  slot_e             slot;
  logic [BYTE_W-1:0] min_q, min_d;
  logic [BYTE_W-1:0] hour_q, hour_d;
  logic [BYTE_W-1:0] day_q, day_d;
  logic              wr_en;

  // address decode
  always_comb begin
    if (addr_i == ADDR_W'(ADR_MIN))       slot = SLOT_MIN;
    else if (addr_i == ADDR_W'(ADR_HOUR)) slot = SLOT_HOUR;
    else if (addr_i == ADDR_W'(ADR_DAY))  slot = SLOT_DAY;
    else                                  slot = SLOT_NONE;
  end

  assign wr_en    = sel_i && we_i;
  assign access_o = sel_i && (slot != SLOT_NONE);

  // next state
  always_comb begin
    min_d  = min_q;
    hour_d = hour_q;
    day_d  = day_q;
    if (wr_en) begin
      unique case (slot)
        SLOT_MIN:  min_d  = wdata_i;
        SLOT_HOUR: hour_d = wdata_i;
        SLOT_DAY:  day_d  = {wdata_i[MASK_POS], {PAD_W{1'b0}}, wdata_i[DAY_W-1:0]};
        default:   ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
    end else if (wr_en) begin
      min_q  <= min_d;
      hour_q <= hour_d;
      day_q  <= day_d;
    end
  end

  // read mux
  always_comb begin
    unique case (slot)
      SLOT_MIN:  rdata_o = min_q;
      SLOT_HOUR: rdata_o = hour_q;
      SLOT_DAY:  rdata_o = day_q;
      default:   rdata_o = '0;
    endcase
  end

  assign min_q_o  = min_q;
  assign hour_q_o = hour_q;
  assign day_q_o  = day_q;

  // R2: a write leaves the other two alarm bytes untouched
  p_write_isolated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && slot == SLOT_MIN) |=> ($stable(hour_q) && $stable(day_q)));
endmodule

// File: rtl/tod_alarm_field.sv
module tod_alarm_field #(
  parameter int unsigned W = 7
) (
  input  logic         mask_i,
  input  logic [W-1:0] alarm_i,
  input  logic [W-1:0] now_i,
  output logic         ok_o
);
  // a masked field is a don't-care
  always_comb ok_o = mask_i || (alarm_i == now_i);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic [BYTE_W-1:0] min_q_i,
  input  logic [BYTE_W-1:0] hour_q_i,
  input  logic [BYTE_W-1:0] day_q_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [DAY_W-1:0]  cur_day_i,
  output logic              hit_o
);
  logic ok_min, ok_hour, ok_day;

  tod_alarm_field #(.W(MIN_W)) u_min (
    .mask_i  (min_q_i[MASK_POS]),
    .alarm_i (min_q_i[MIN_W-1:0]),
    .now_i   (cur_min_i),
    .ok_o    (ok_min)
  );

  tod_alarm_field #(.W(HOUR_W)) u_hour (
    .mask_i  (hour_q_i[MASK_POS]),
    .alarm_i (hour_q_i[HOUR_W-1:0]),
    .now_i   (cur_hour_i),
    .ok_o    (ok_hour)
  );

  tod_alarm_field #(.W(DAY_W)) u_day (
    .mask_i  (day_q_i[MASK_POS]),
    .alarm_i (day_q_i[DAY_W-1:0]),
    .now_i   (cur_day_i),
    .ok_o    (ok_day)
  );

  assign hit_o = ok_min && ok_hour && ok_day;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic min_edge_i,
  input  logic hit_i,
  input  logic access_i,
  output logic flag_o
);
  logic flag_q, flag_d, event_set;

  assign event_set = min_edge_i && hit_i;

  // next state: a new event outranks an acknowledge
  always_comb begin
    flag_d = flag_q;
    if (event_set)     flag_d = 1'b1;
    else if (access_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R8
  p_event_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_edge_i && hit_i) |=> flag_o);
  // R9
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !(min_edge_i && hit_i)) |=> !flag_o);
  // R11
  p_rise_needs_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !min_edge_i && !access_i |=> $stable(flag_o));
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic                min_edge_i,
  input  logic [6:0]          cur_min_i,
  input  logic [6:0]          cur_hour_i,
  input  logic [2:0]          cur_day_i,
  output logic                alarm_flag_o,
  output logic                alarm_irq_no
);
  logic [BYTE_W-1:0] min_q, hour_q, day_q;
  logic              access, hit, flag;

  tod_alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .min_q_o  (min_q),
    .hour_q_o (hour_q),
    .day_q_o  (day_q),
    .access_o (access)
  );

  tod_alarm_match u_match (
    .min_q_i    (min_q),
    .hour_q_i   (hour_q),
    .day_q_i    (day_q),
    .cur_min_i  (cur_min_i),
    .cur_hour_i (cur_hour_i),
    .cur_day_i  (cur_day_i),
    .hit_o      (hit)
  );

  tod_alarm_flag u_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .min_edge_i (min_edge_i),
    .hit_i      (hit),
    .access_i   (access),
    .flag_o     (flag)
  );

  assign alarm_flag_o = flag;
  assign alarm_irq_no = ~flag;

  // R3: padding bits of the day byte never read back
  p_day_pad_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(ADR_DAY)) |-> (bus_rdata_o[6:3] == 4'b0000));
  // R7: all masks set means every strobe raises the flag
  p_all_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_edge_i && min_q[MASK_POS] && hour_q[MASK_POS] && day_q[MASK_POS]) |=> alarm_flag_o);
  // R8: interrupt pin mirrors the flag inverted
  p_irq_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_flag_o |-> !alarm_irq_no);
endmodule

// File: tb/tod_alarm_unit_test.sv
module tod_alarm_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, we, edge_s;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [6:0] cmin, chour;
  logic [2:0] cday;
  logic       flag, irq_n;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  logic [7:0] m_min, m_hour, m_day;
  bit         m_flag;

  always #2 clk = ~clk;   // 250 MHz

  tod_alarm_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .min_edge_i(edge_s), .cur_min_i(cmin), .cur_hour_i(chour), .cur_day_i(cday),
    .alarm_flag_o(flag), .alarm_irq_no(irq_n)
  );

  function automatic logic [7:0] ref_read(input logic [3:0] a);
    case (a)
      4'd3:    return m_min;
      4'd5:    return m_hour;
      4'd7:    return m_day;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit ref_hit();
    bit okm, okh, okd;
    okm = m_min[7]  || (m_min[6:0]  == cmin);
    okh = m_hour[7] || (m_hour[6:0] == chour);
    okd = m_day[7]  || (m_day[2:0]  == cday);
    return okm && okh && okd;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one bus/time cycle: drive, compare against model, advance model
  task automatic cyc(input string tag, input bit s, input bit w, input logic [3:0] a,
                     input logic [7:0] d, input bit e,
                     input logic [6:0] mn, input logic [6:0] hr, input logic [2:0] dy);
    bit hit, acc;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; edge_s = e;
    cmin = mn; chour = hr; cday = dy;
    #1;
    chk(tag, "rdata", rdata, ref_read(a));
    chk(tag, "flag",  flag,  m_flag);
    chk(tag, "irq_n", irq_n, !m_flag);
    hit = ref_hit();
    acc = s && (a == 4'd3 || a == 4'd5 || a == 4'd7);
    if (e && hit)  m_flag = 1;
    else if (acc)  m_flag = 0;
    if (s && w) begin
      if (a == 4'd3) m_min  = d;
      if (a == 4'd5) m_hour = d;
      if (a == 4'd7) m_day  = d & 8'h87;
    end
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
    cyc(tag, 1, 1, a, d, 0, 7'h00, 7'h00, 3'd0);
  endtask
  task automatic rd(input string tag, input logic [3:0] a);
    cyc(tag, 1, 0, a, 8'h00, 0, 7'h00, 7'h00, 3'd0);
  endtask
  task automatic tick(input string tag, input bit e, input logic [6:0] mn,
                      input logic [6:0] hr, input logic [2:0] dy);
    cyc(tag, 0, 0, 4'd0, 8'h00, e, mn, hr, dy);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    m_min = 0; m_hour = 0; m_day = 0; m_flag = 0;
    sel = 0; we = 0; addr = 0; wdata = 0; edge_s = 0; cmin = 0; chour = 0; cday = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    rd("R1", 4'd3); rd("R1", 4'd5); rd("R1", 4'd7);
    // R2 write / read-back, foreign address ignored
    wr("R2", 4'd3, 8'h30); wr("R2", 4'd5, 8'h12); wr("R2", 4'd4, 8'hFF);
    rd("R2", 4'd3); rd("R2", 4'd5); rd("R2", 4'd4); rd("R2", 4'd6);
    // R3 padding bits
    wr("R3", 4'd7, 8'hFF); rd("R3", 4'd7);
    wr("R3", 4'd7, 8'h03); rd("R3", 4'd7);
    // R4 weekly: single-field mismatches, then full match
    tick("R4", 1, 7'h30, 7'h12, 3'd4);
    tick("R4", 1, 7'h30, 7'h52, 3'd3);   // 12/24 select differs
    tick("R4", 1, 7'h31, 7'h12, 3'd3);
    tick("R4", 1, 7'h30, 7'h12, 3'd3);
    tick("R8", 0, 7'h30, 7'h12, 3'd3);
    tick("R8", 0, 7'h30, 7'h12, 3'd3);
    // R9 foreign access keeps flag, alarm read clears
    rd("R9", 4'd4); rd("R9", 4'd2); rd("R9", 4'd5); tick("R9", 0, 7'h30, 7'h12, 3'd3);
    // R11 matching time held without strobe
    tick("R11", 0, 7'h30, 7'h12, 3'd3); tick("R11", 0, 7'h30, 7'h12, 3'd3);
    tick("R11", 0, 7'h30, 7'h12, 3'd3);
    // R5 daily
    wr("R5", 4'd7, 8'h83);
    tick("R5", 1, 7'h30, 7'h12, 3'd5); tick("R5", 0, 7'h30, 7'h12, 3'd5);
    wr("R9", 4'd3, 8'h30); tick("R9", 0, 7'h00, 7'h00, 3'd0);
    tick("R5", 1, 7'h30, 7'h13, 3'd5); tick("R5", 0, 7'h30, 7'h13, 3'd5);
    // R6 hourly
    wr("R6", 4'd5, 8'h92);
    tick("R6", 1, 7'h31, 7'h07, 3'd1); tick("R6", 1, 7'h30, 7'h07, 3'd1);
    tick("R6", 0, 7'h30, 7'h07, 3'd1); rd("R9", 4'd7);
    // R7 every minute
    wr("R7", 4'd3, 8'hB0);
    tick("R7", 1, 7'h59, 7'h23, 3'd6); tick("R7", 0, 7'h00, 7'h00, 3'd0);
    // R10 strobe and acknowledge in the same cycle
    cyc("R10", 1, 0, 4'd3, 8'h00, 1, 7'h11, 7'h11, 3'd2);
    tick("R10", 0, 7'h00, 7'h00, 3'd0);
    cyc("R10", 1, 1, 4'd5, 8'h92, 1, 7'h11, 7'h11, 3'd2);
    tick("R10", 0, 7'h00, 7'h00, 3'd0);

    // mixed pseudo-random phase against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:1])
        2'd0: a = 4'd3;
        2'd1: a = 4'd5;
        2'd2: a = 4'd7;
        default: a = 4'd6;
      endcase
      cyc("R4", lfsr[3] && lfsr[4], lfsr[5], a,
          {lfsr[6], 3'b000, 1'b0, lfsr[7] ? 3'd3 : 3'd5} | (a == 4'd5 ? 8'h12 : 8'h30),
          lfsr[8],
          lfsr[9]  ? 7'h30 : 7'h31,
          lfsr[10] ? 7'h12 : 7'h13,
          lfsr[11] ? 3'd3 : 3'd5);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule